// File: doc/BRIEF.md
# Self-Withdrawing Wired-AND Bus Arbiter

This block decides which of eight modules gets to use a shared resource. It does not use a central priority encoder. It models a 3-bit open-drain arbitration bus as a wired-AND. Every contending module drives its own identifier onto the lines. A 0 bit pulls a line low, and a 1 bit leaves the line released.

Resolution runs one line per clock, starting from the most significant line. A contender whose own bit is 1 while the resolved line reads 0 has lost. It releases all of its lines at once. After three steps a single contender is left, and that is always the lowest-numbered one. It holds a grant until it signals that it is finished.

A fairness rule prevents a high-numbered module from starving. A served module is blocked from later rounds as long as any unblocked module is still requesting. Once no unblocked request remains, every blocked module is released in one step.

Top module: `wab_arbiter`

## Requirements
- R1: The resolved bus equals the bitwise AND of the identifiers of all modules still contending. A module that is not contending leaves every line at 1, so the bus reads 3'b111 when no module contends.
- R2: Suppose an unblocked request is present on a clock edge while the arbiter is idle. Then grant stays all-zero for the next three edges and becomes valid right after the fourth edge, one edge per identifier bit.
- R3: The winner is the requesting, unblocked module with the lowest identifier. While its grant is high, the bus shows the winner's identifier in binary.
- R4: At most one grant bit is high in any cycle.
- R5: A grant stays high until the edge on which the winner's own done bit is sampled high, and it is low right after that edge. Done bits of other modules have no effect on the grant.
- R6: The set of contenders is fixed on the edge that starts a round. Request changes during resolution do not change that round's winner.
- R7: A served module gets no grant while any unblocked module is requesting. A new unblocked requester with a lower identifier is served ahead of the modules still waiting in the batch.
- R8: Suppose the arbiter is idle, at least one module is blocked, and no unblocked request is present. Then all blocked modules are released on that edge, and a new round can start on the next edge.
- R9: With no request present, no grant is given and the bus stays 3'b111.
- R10: After reset there is no grant, the bus reads 3'b111 and no module is blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 8 | Request, one bit per module |
| done | input | 8 | End of use, one bit per module; only the winner's bit counts |
| grant | output | 8 | Grant, one bit per module, at most one high |
| arb_bus | output | 3 | Resolved wired-AND arbitration lines |

## Verification
Inputs change on falling edges. A round started by an edge has its grant due after the fourth rising edge, so the bench checks that grant is still zero after the third edge and holds the expected winner after the fourth. A batch release adds exactly one edge before the round starts. The bench keeps its own record of blocked modules to know when that extra edge is due. Grant removal is checked on the falling edge right after the edge that sampled done, and grant stability is checked on every falling edge while done stays away from the winner.

// File: rtl/wab_pkg.sv
package wab_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RESOLVE = 2'd1,
    PH_HOLD    = 2'd2
  } wab_phase_e;

  // A contender stays in as long as the resolved line agrees with its own bit.
  function automatic logic stays_in(input logic own_bit, input logic line_val);
    return own_bit == line_val;
  endfunction

  // Open-drain value a module places on its lines.
  function automatic logic [7:0] drive_of(input logic active, input logic [7:0] ident);
    return active ? ident : 8'hFF;
  endfunction
endpackage

// File: rtl/wab_contender.sv
module wab_contender #(
  parameter int ID_W = 3,
  parameter int ID   = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_val,
  input  logic            clear,
  input  logic [ID_W-1:0] step_mask,
  input  logic [ID_W-1:0] bus_val,
  output logic            alive,
  output logic [ID_W-1:0] drive
);
  import wab_pkg::*;

  localparam logic [ID_W-1:0] ID_VEC = ID_W'(ID);

  logic own_bit;
  logic line_bit;
  logic stepping;
  logic lose;

  assign own_bit  = |(ID_VEC & step_mask);
  assign line_bit = |(bus_val & step_mask);
  assign stepping = |step_mask;
  assign lose     = stepping && alive && !stays_in(own_bit, line_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alive <= 1'b0;
    else if (load)   alive <= load_val;
    else if (clear)  alive <= 1'b0;
    else if (lose)   alive <= 1'b0;
  end

  always_comb begin
    logic [7:0] full;
    full  = drive_of(alive, 8'(ID_VEC));
    drive = full[ID_W-1:0];
  end

  // R6
  no_rejoin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alive && !load) |=> !alive);

  // R1
  own_zero_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alive && stepping && !own_bit) |-> !line_bit);
endmodule

// File: rtl/wab_sequencer.sv
module wab_sequencer #(
  parameter int N_MOD = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MOD-1:0] req,
  input  logic [N_MOD-1:0] done,
  input  logic [N_MOD-1:0] alive,
  output logic             load,
  output logic [N_MOD-1:0] load_mask,
  output logic             clear,
  output logic [ID_W-1:0]  step_mask,
  output logic             hold,
  output logic             release_ev,
  output logic [N_MOD-1:0] blocked
);
  import wab_pkg::*;

  localparam logic [ID_W-1:0] TOP_BIT = {1'b1, {(ID_W-1){1'b0}}};

  wab_phase_e      phase;
  logic [ID_W-1:0] bit_q;
  logic [N_MOD-1:0] eligible;
  logic            finish;

  assign eligible   = req & ~blocked;
  assign load       = (phase == PH_IDLE) && |eligible;
  assign load_mask  = eligible;
  assign release_ev = (phase == PH_IDLE) && !(|eligible) && |blocked;
  assign hold       = (phase == PH_HOLD);
  assign finish     = hold && |(done & alive);
  assign clear      = finish;
  assign step_mask  = (phase == PH_RESOLVE) ? bit_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_q   <= '0;
      blocked <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (load) begin
            phase <= PH_RESOLVE;
            bit_q <= TOP_BIT;
          end else if (release_ev) begin
            blocked <= '0;
          end
        end
        PH_RESOLVE: begin
          bit_q <= bit_q >> 1;
          if (bit_q[0]) phase <= PH_HOLD;
        end
        PH_HOLD: begin
          if (finish) begin
            blocked <= blocked | alive;
            phase   <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  resolve_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(load, ID_W + 1));

  // R8
  batch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> (blocked == '0));

  // R7
  served_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> ((blocked & $past(alive)) == $past(alive)));
endmodule

// File: rtl/wab_arbiter.sv
module wab_arbiter #(
  parameter int N_MOD = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MOD-1:0] req,
  input  logic [N_MOD-1:0] done,
  output logic [N_MOD-1:0] grant,
  output logic [ID_W-1:0]  arb_bus
);
  logic                        load;
  logic [N_MOD-1:0]            load_mask;
  logic                        clear;
  logic [ID_W-1:0]             step_mask;
  logic                        hold;
  logic                        release_ev;
  logic [N_MOD-1:0]            blocked;
  logic [N_MOD-1:0]            alive;
  logic [N_MOD-1:0][ID_W-1:0]  drv;

  wab_sequencer #(.N_MOD(N_MOD), .ID_W(ID_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .alive(alive),
    .load(load), .load_mask(load_mask), .clear(clear), .step_mask(step_mask),
    .hold(hold), .release_ev(release_ev), .blocked(blocked)
  );

  for (genvar m = 0; m < N_MOD; m++) begin : g_node
    wab_contender #(.ID_W(ID_W), .ID(m)) i_node (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_mask[m]),
      .clear(clear), .step_mask(step_mask), .bus_val(arb_bus),
      .alive(alive[m]), .drive(drv[m])
    );
  end

  // Wired-AND of every open-drain driver.
  always_comb begin
    arb_bus = '1;
    for (int m = 0; m < N_MOD; m++) arb_bus = arb_bus & drv[m];
  end

  assign grant = hold ? alive : '0;

  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alive == '0) |-> (arb_bus == '1));

  // R3
  winner_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ($onehot(grant) && grant[arb_bus]));

  // R5
  grant_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !(|(done & grant))) |=> (grant == $past(grant)));

  // R7
  no_blocked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ((grant & blocked) == '0));
endmodule

// File: tb/test_wab_arbiter.sv
module test_wab_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_r = '0;
  logic [7:0] done_r = '0;
  logic [7:0] grant;
  logic [2:0] arb_bus;
  logic [7:0] blk = '0;
  int total = 0;
  int bad = 0;

  wab_arbiter i_wab_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req_r), .done(done_r),
    .grant(grant), .arb_bus(arb_bus)
  );

  always #4 clk = ~clk;

  // {request mask, expected winner (8 = none)}
  localparam logic [11:0] VEC [8] = '{
    {8'b1000_0000, 4'd7}, {8'b1111_1111, 4'd0}, {8'b1010_0000, 4'd5},
    {8'b0000_0000, 4'd8}, {8'b0110_0000, 4'd5}, {8'b1100_1000, 4'd3},
    {8'b0001_0100, 4'd2}, {8'b1100_0000, 4'd6}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_r = '0; done_r = '0; blk = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One round from idle; swap[8] set replaces the request after the start edge.
  task automatic do_round(input int want, input int linger, input logic [8:0] swap);
    logic [7:0] elig;
    int pre;
    elig = req_r & ~blk;
    pre = 0;
    if (elig == 0 && blk != 0) begin blk = '0; pre = 1; end
    repeat (pre + 1) @(negedge clk);
    if (swap[8]) req_r = swap[7:0];
    repeat (2) @(negedge clk);
    check(grant == 0, "R2 grant early", grant, 0);
    @(negedge clk);
    if (want == 8) begin
      check(grant == 0, "R9 grant", grant, 0);
      check(arb_bus == 3'b111, "R9 bus", arb_bus, 7);
      return;
    end
    check(grant == 8'(1 << want), "R3 winner", grant, 1 << want);
    check(arb_bus == 3'(want), "R3 bus", arb_bus, want);
    for (int k = 0; k < linger; k++) begin
      done_r = ~8'(1 << want);
      @(negedge clk);
      check(grant == 8'(1 << want), "R5 hold", grant, 1 << want);
    end
    done_r = 8'(1 << want);
    @(negedge clk);
    done_r = '0;
    blk = blk | 8'(1 << want);
    check(grant == 0, "R5 drop", grant, 0);
    check(arb_bus == 3'b111, "R1 idle bus", arb_bus, 7);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(grant == 0, "R10 reset grant", grant, 0);
    check(arb_bus == 3'b111, "R10 reset bus", arb_bus, 7);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      do_reset();
      req_r = VEC[v][11:4];
      do_round(int'(VEC[v][3:0]), 0, 9'h0);
    end

    // R7 / R8: batch of 1,3,6, with 0 joining mid-batch
    do_reset();
    req_r = 8'b0100_1010;
    do_round(1, 0, 9'h0);
    req_r = 8'b0100_1011;
    do_round(0, 0, 9'h0);
    do_round(3, 0, 9'h0);
    do_round(6, 0, 9'h0);
    do_round(0, 0, 9'h0);   // R8 release then new round
    do_round(1, 0, 9'h0);

    // R5: other modules' done ignored while the winner holds
    do_reset();
    req_r = 8'b1010_0000;
    do_round(5, 4, 9'h0);

    // R6: request change during resolution ignored
    do_reset();
    req_r = 8'b0000_0110;
    do_round(1, 0, {1'b1, 8'b0000_0001});
    do_round(0, 0, 9'h0);

    // R9 after release with nothing pending
    do_reset();
    req_r = 8'b0000_1000;
    do_round(3, 0, 9'h0);
    req_r = '0;
    do_round(8, 0, 9'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule